// File: doc/BRIEF.md
# Register-Port to Stream FIFO Bridge

This block joins a plain 32-bit register port, driven by a processor with single-cycle write and read strobes, to a full-duplex AXI4-Stream pair. Words the processor writes to the transmit data register are queued in a transmit FIFO. They leave on the outgoing stream once a packet length has been programmed, and the bridge raises TLAST on the last beat of each packet of that length. Words arriving on the incoming stream are queued in a receive FIFO, and the processor removes them one at a time by reading the receive data register.

The processor learns whether it may write or read by polling one status word. That word holds the free space left on the transmit side, the number of words held on the receive side, a flag showing that a TLAST beat has arrived, and a sticky error flag. The error flag records a write that found the transmit queue full or a read that found the receive queue empty. Both queues are held in block-RAM-style storage with a one-word registered head, and the whole block runs on one clock.

Top module: `mmst_adapter`

## Requirements
- R1: After reset, status reads transmit vacancy 512, receive occupancy 0 and both flags 0. The outgoing TVALID is low and the incoming TREADY is high.
- R2: A write to offset 0x0 queues one word. The words leave on the outgoing stream in the order they were written, and the transmit vacancy falls by one for each word queued.
- R3: Offset 0x8 holds the packet length in bits [15:0]. TLAST is high on the beat whose count since the start of the packet equals that length, and the next beat starts a new packet. Writing the length register restarts the count at zero.
- R4: No beat is offered on the outgoing stream while the programmed length is zero or the transmit queue is empty.
- R5: A beat moves only in a cycle where TVALID and TREADY are both high. While TREADY is low, the offered TVALID and TDATA stay unchanged.
- R6: Incoming beats are queued while TREADY is high. Each read of offset 0x4 returns the oldest queued word on reg_rdata in the cycle after the read strobe and removes that word.
- R7: A read of offset 0xC returns transmit vacancy in bits [9:0], receive occupancy in bits [25:16], the sticky error flag in bit 30 and the TLAST-received flag in bit 31. Writing 1 to bit 30 or bit 31 clears that flag.
- R8: A write to 0x0 while the transmit queue holds 512 words is discarded and sets the error flag. The discarded word never appears on the stream.
- R9: A read of 0x4 while no received word is available returns 0, removes nothing and sets the error flag.
- R10: When the receive queue holds 512 words, the incoming TREADY is low and no further word is accepted.
- R11: The TLAST-received flag is set when an incoming beat with TLAST high is accepted, and it stays set until it is cleared. Beats without TLAST leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| m_tdata | output | 32 | Outgoing stream data |
| m_tvalid | output | 1 | Outgoing stream valid |
| m_tready | input | 1 | Outgoing stream ready |
| m_tlast | output | 1 | Outgoing end of packet |
| s_tdata | input | 32 | Incoming stream data |
| s_tvalid | input | 1 | Incoming stream valid |
| s_tready | output | 1 | Incoming stream ready |
| s_tlast | input | 1 | Incoming end of packet |

## Verification
The hardest states to reach are the two full queues, because the ports give no direct way to fill a queue. The transmit side is filled by holding the length at zero and TREADY low while 512 words are written. The bench then writes a 513th word, checks the error flag, releases the length and confirms that exactly 512 beats leave with a single TLAST. The receive side is filled by offering a continuous incoming stream with the processor idle until TREADY drops, counting the accepted beats, and then draining the queue to confirm the order. The bench also holds TREADY low against a live packet so that the hold rule and the packet count are checked across stalls.

// File: rtl/mmst_pkg.sv
package mmst_pkg;
  // Word-index decode of reg_addr[3:2]
  typedef enum logic [1:0] {
    SEL_TXPUSH = 2'd0,
    SEL_RXPOP  = 2'd1,
    SEL_TXLEN  = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  localparam int ST_RXOCC_LSB = 16;
  localparam int ST_ERR       = 30;
  localparam int ST_RXLAST    = 31;
endpackage

// File: rtl/mmst_fifo.sv
// Synchronous FIFO: RAM array plus a registered head word (first word falls through).
module mmst_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             rd_vld,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_ack,
  output logic [CW-1:0]    occ
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    mem_cnt, occ_q;
  logic             head_vld_q;
  logic [WIDTH-1:0] head_q;
  logic             push_ok, deq, load;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = wr_en && (occ_q != FULL_C);
  assign deq     = head_vld_q && rd_ack;
  assign load    = (mem_cnt != '0) && (!head_vld_q || rd_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      mem_cnt    <= '0;
      occ_q      <= '0;
      head_vld_q <= 1'b0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (load)    rptr <= bump(rptr);
      mem_cnt <= mem_cnt + CW'(push_ok) - CW'(load);
      occ_q   <= occ_q + CW'(push_ok) - CW'(deq);
      if (load)     head_vld_q <= 1'b1;
      else if (deq) head_vld_q <= 1'b0;
    end
  end

  // Storage without reset so that a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_data;
    if (load)    head_q    <= mem[rptr];
  end

  assign full    = (occ_q == FULL_C);
  assign occ     = occ_q;
  assign rd_vld  = head_vld_q;
  assign rd_data = head_q;

  assert_occ_track_R2: assert property (@(posedge clk) disable iff (rst)
    occ_q == mem_cnt + CW'(head_vld_q));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    occ_q <= FULL_C);
  assert_head_hold_R5: assert property (@(posedge clk) disable iff (rst)
    head_vld_q && !rd_ack |=> head_vld_q && $stable(head_q));
endmodule

// File: rtl/mmst_tx_framer.sv
// Counts outgoing beats against the programmed length and marks the packet end.
module mmst_tx_framer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_q,
  input  logic             len_wr,
  input  logic             head_vld,
  input  logic             m_tready,
  output logic             m_tvalid,
  output logic             m_tlast,
  output logic             beat
);
  logic [LEN_W-1:0] cnt_q, nxt;

  assign nxt      = cnt_q + 1'b1;
  assign m_tvalid = head_vld && (len_q != '0);
  assign m_tlast  = m_tvalid && (nxt == len_q);
  assign beat     = m_tvalid && m_tready;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (len_wr)  cnt_q <= '0;
    else if (beat)    cnt_q <= m_tlast ? '0 : nxt;
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    (len_q != '0) |-> cnt_q < len_q);
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready && !len_wr |=> m_tvalid);
endmodule

// File: rtl/mmst_regfile.sv
// Register decode, packet length, sticky flags and registered read data.
module mmst_regfile
  import mmst_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  parameter int LEN_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             tx_full,
  input  logic [CW-1:0]    tx_occ,
  output logic             tx_push,
  output logic [DW-1:0]    tx_wdata,
  input  logic [CW-1:0]    rx_occ,
  input  logic             rx_vld,
  input  logic [DW-1:0]    rx_data,
  output logic             rx_pop,
  input  logic             rx_last_evt,
  output logic [LEN_W-1:0] len_q,
  output logic             len_wr
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  reg_sel_e      sel;
  logic          push_drop, pop_drop, stat_wr;
  logic          err_q, rxl_q;
  logic [DW-1:0] stat;

  assign sel       = reg_sel_e'(reg_addr[3:2]);
  assign tx_push   = reg_wr && (sel == SEL_TXPUSH) && !tx_full;
  assign push_drop = reg_wr && (sel == SEL_TXPUSH) && tx_full;
  assign tx_wdata  = reg_wdata;
  assign rx_pop    = reg_rd && (sel == SEL_RXPOP) && rx_vld;
  assign pop_drop  = reg_rd && (sel == SEL_RXPOP) && !rx_vld;
  assign stat_wr   = reg_wr && (sel == SEL_STAT);
  assign len_wr    = reg_wr && (sel == SEL_TXLEN);

  always_comb begin
    stat                          = '0;
    stat[CW-1:0]                  = DEPTH_C - tx_occ;
    stat[ST_RXOCC_LSB +: CW]      = rx_occ;
    stat[ST_ERR]                  = err_q;
    stat[ST_RXLAST]               = rxl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      err_q     <= 1'b0;
      rxl_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (len_wr) len_q <= reg_wdata[LEN_W-1:0];

      if (push_drop || pop_drop)             err_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_ERR]) err_q <= 1'b0;

      if (rx_last_evt)                          rxl_q <= 1'b1;
      else if (stat_wr && reg_wdata[ST_RXLAST]) rxl_q <= 1'b0;

      if (reg_rd) begin
        case (sel)
          SEL_RXPOP: reg_rdata <= rx_vld ? rx_data : '0;
          SEL_TXLEN: reg_rdata <= DW'(len_q);
          SEL_STAT:  reg_rdata <= stat;
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_q && !(stat_wr && reg_wdata[ST_ERR]) |=> err_q);
  assert_rxlast_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    rxl_q && !(stat_wr && reg_wdata[ST_RXLAST]) |=> rxl_q);
endmodule

// File: rtl/mmst_adapter.sv
module mmst_adapter #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int LEN_W  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast
);
  logic              tx_push, tx_full, tx_head_vld, tx_beat;
  logic [DATA_W-1:0] tx_wdata;
  logic [CW-1:0]     tx_occ, rx_occ;
  logic              rx_full, rx_vld, rx_pop, rx_push;
  logic [DATA_W-1:0] rx_data;
  logic [LEN_W-1:0]  len_q;
  logic              len_wr;

  assign s_tready = !rx_full;
  assign rx_push  = s_tvalid && s_tready;

  mmst_regfile #(.DW(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_full(tx_full), .tx_occ(tx_occ), .tx_push(tx_push), .tx_wdata(tx_wdata),
    .rx_occ(rx_occ), .rx_vld(rx_vld), .rx_data(rx_data), .rx_pop(rx_pop),
    .rx_last_evt(rx_push && s_tlast),
    .len_q(len_q), .len_wr(len_wr)
  );

  mmst_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txq_i (
    .clk(clk), .rst(rst),
    .wr_en(tx_push), .wr_data(tx_wdata), .full(tx_full),
    .rd_vld(tx_head_vld), .rd_data(m_tdata), .rd_ack(tx_beat),
    .occ(tx_occ)
  );

  mmst_tx_framer #(.LEN_W(LEN_W)) framer_i (
    .clk(clk), .rst(rst),
    .len_q(len_q), .len_wr(len_wr),
    .head_vld(tx_head_vld), .m_tready(m_tready),
    .m_tvalid(m_tvalid), .m_tlast(m_tlast), .beat(tx_beat)
  );

  mmst_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxq_i (
    .clk(clk), .rst(rst),
    .wr_en(rx_push), .wr_data(s_tdata), .full(rx_full),
    .rd_vld(rx_vld), .rd_data(rx_data), .rd_ack(rx_pop),
    .occ(rx_occ)
  );

  assert_valid_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> tx_occ != '0);
  assert_rx_full_stall_R10: assert property (@(posedge clk) disable iff (rst)
    s_tvalid && !s_tready |=> rx_occ <= $past(rx_occ));
endmodule

// File: tb/mmst_adapter_tb.sv
module mmst_adapter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] m_tdata;
  logic        m_tvalid, m_tlast;
  logic        m_tready = 1'b0;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0, s_tlast = 1'b0;
  logic        s_tready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the outgoing stream
  logic [31:0] exp_tx[$];
  int unsigned len_m = 0, cnt_m = 0;
  int beats = 0, lasts = 0;
  bit prev_stall = 0;
  logic [31:0] prev_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmst_adapter dut_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Outgoing stream monitor, sampled 1 time unit after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (prev_stall && !rst) begin
      chk("R5 tvalid held during stall", {31'd0, m_tvalid}, 32'd1);
      chk("R5 tdata held during stall", m_tdata, prev_data);
    end
    prev_stall = m_tvalid && !m_tready;
    prev_data  = m_tdata;
    if (m_tvalid && m_tready) begin
      beats++;
      if (exp_tx.size() == 0) begin
        chk("R2 unexpected outgoing beat", m_tdata, 32'hxxxx_xxxx);
      end else begin
        logic [31:0] e;
        bit el;
        e = exp_tx.pop_front();
        cnt_m++;
        el = (cnt_m == len_m);
        if (el) cnt_m = 0;
        chk("R2 outgoing word order", m_tdata, e);
        chk("R3 tlast position", {31'd0, m_tlast}, {31'd0, el});
      end
      if (m_tlast) lasts++;
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 4'h8) begin len_m = d[15:0]; cnt_m = 0; end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tx_push(input logic [31:0] d, input bit accepted);
    if (accepted) exp_tx.push_back(d);
    reg_write(4'h0, d);
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send_rx(input logic [31:0] d, input bit last, input int tries, output bit acc);
    acc = 0;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
    for (int t = 0; t < tries; t++) begin
      #1;
      if (s_tready) acc = 1;
      @(negedge clk);
      if (acc) break;
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] st;
    #1;
    chk("R1 m_tvalid after reset", {31'd0, m_tvalid}, 32'd0);
    chk("R1 s_tready after reset", {31'd0, s_tready}, 32'd1);
    reg_read(4'hC, st);
    chk("R1 R7 status after reset", st, 32'h0000_0200);
  endtask

  task automatic t_zero_len;
    int b0, l0;
    logic [31:0] st;
    m_tready = 1'b1;
    b0 = beats; l0 = lasts;
    tx_push(32'hA000_0001, 1);
    tx_push(32'hA000_0002, 1);
    tx_push(32'hA000_0003, 1);
    idle(10);
    chk("R4 no beats with zero length", beats - b0, 0);
    chk("R4 tvalid low with zero length", {31'd0, m_tvalid}, 32'd0);
    reg_read(4'hC, st);
    chk("R2 R7 vacancy after three pushes", {22'd0, st[9:0]}, 32'd509);
    reg_write(4'h8, 32'd3);
    idle(10);
    chk("R2 three beats sent", beats - b0, 3);
    chk("R3 one packet end", lasts - l0, 1);
    chk("R4 tvalid low with empty queue", {31'd0, m_tvalid}, 32'd0);
  endtask

  task automatic t_backpressure;
    int b0, l0;
    m_tready = 1'b0;
    b0 = beats; l0 = lasts;
    reg_write(4'h8, 32'd4);
    for (int i = 0; i < 8; i++) tx_push(32'hB000_0000 + i, 1);
    idle(5);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      m_tready = (i % 3) != 0;
    end
    @(negedge clk);
    m_tready = 1'b1;
    idle(5);
    chk("R5 eight beats under backpressure", beats - b0, 8);
    chk("R3 two packet ends of length four", lasts - l0, 2);
  endtask

  task automatic t_len_restart;
    int b0, l0;
    m_tready = 1'b1;
    b0 = beats; l0 = lasts;
    reg_write(4'h8, 32'd5);
    tx_push(32'hC000_0001, 1);
    tx_push(32'hC000_0002, 1);
    idle(6);
    chk("R3 partial packet has no tlast", lasts - l0, 0);
    reg_write(4'h8, 32'd2);
    tx_push(32'hC000_0003, 1);
    tx_push(32'hC000_0004, 1);
    idle(6);
    chk("R3 count restarted by length write", lasts - l0, 1);
    chk("R3 four beats in restart test", beats - b0, 4);
  endtask

  task automatic t_tx_full;
    int b0, l0;
    logic [31:0] st;
    m_tready = 1'b0;
    reg_write(4'h8, 32'd0);
    b0 = beats; l0 = lasts;
    for (int i = 0; i < DEPTH; i++) tx_push(32'h1000_0000 + i, 1);
    reg_read(4'hC, st);
    chk("R8 vacancy zero when full", {22'd0, st[9:0]}, 32'd0);
    chk("R8 no error before overflow", {31'd0, st[30]}, 32'd0);
    tx_push(32'hDEAD_BEEF, 0);
    reg_read(4'hC, st);
    chk("R8 error after push to full queue", {31'd0, st[30]}, 32'd1);
    chk("R8 vacancy still zero", {22'd0, st[9:0]}, 32'd0);
    reg_write(4'h8, DEPTH);
    m_tready = 1'b1;
    idle(DEPTH + 10);
    chk("R8 exactly 512 beats drained", beats - b0, DEPTH);
    chk("R3 single tlast for length 512", lasts - l0, 1);
    chk("R8 dropped word absent", exp_tx.size(), 0);
    reg_read(4'hC, st);
    chk("R2 vacancy restored", {22'd0, st[9:0]}, 32'd512);
    reg_write(4'hC, 32'h4000_0000);
    reg_read(4'hC, st);
    chk("R7 error cleared by writing one", {31'd0, st[30]}, 32'd0);
  endtask

  task automatic t_rx_basic;
    bit acc;
    logic [31:0] st, d;
    send_rx(32'hD000_0001, 0, 8, acc);
    idle(2);
    send_rx(32'hD000_0002, 0, 8, acc);
    idle(3);
    reg_read(4'hC, st);
    chk("R11 flag unchanged by non-last beats", {31'd0, st[31]}, 32'd0);
    send_rx(32'hD000_0003, 1, 8, acc);
    idle(3);
    reg_read(4'hC, st);
    chk("R7 receive occupancy three", {22'd0, st[25:16]}, 32'd3);
    chk("R11 tlast flag set", {31'd0, st[31]}, 32'd1);
    chk("R7 error clear before empty pop", {31'd0, st[30]}, 32'd0);
    reg_read(4'h4, d); chk("R6 first received word", d, 32'hD000_0001);
    reg_read(4'h4, d); chk("R6 second received word", d, 32'hD000_0002);
    reg_read(4'h4, d); chk("R6 third received word", d, 32'hD000_0003);
    reg_read(4'h4, d); chk("R9 empty pop returns zero", d, 32'd0);
    reg_read(4'hC, st);
    chk("R9 error set by empty pop", {31'd0, st[30]}, 32'd1);
    chk("R9 occupancy stays zero", {22'd0, st[25:16]}, 32'd0);
    chk("R11 flag sticky after pops", {31'd0, st[31]}, 32'd1);
    reg_write(4'hC, 32'hC000_0000);
    reg_read(4'hC, st);
    chk("R7 R11 flags cleared by writing one", st, 32'h0000_0200);
  endtask

  task automatic t_rx_full;
    bit acc;
    int n_acc = 0;
    logic [31:0] st, d;
    for (int i = 0; i < DEPTH + 8; i++) begin
      send_rx(32'h5000_0000 + n_acc, 0, 3, acc);
      if (acc) n_acc++;
    end
    chk("R10 accepted beats equal depth", n_acc, DEPTH);
    #1;
    chk("R10 tready low when full", {31'd0, s_tready}, 32'd0);
    reg_read(4'hC, st);
    chk("R10 occupancy 512", {22'd0, st[25:16]}, 32'd512);
    for (int k = 0; k < DEPTH; k++) begin
      reg_read(4'h4, d);
      if (k < 2 || k == DEPTH - 1) chk("R6 R10 drained word order", d, 32'h5000_0000 + k);
      else if (d !== 32'h5000_0000 + k) chk("R6 drained word order", d, 32'h5000_0000 + k);
    end
    reg_read(4'hC, st);
    chk("R6 occupancy zero after drain", {22'd0, st[25:16]}, 32'd0);
    #1;
    chk("R10 tready high after drain", {31'd0, s_tready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_len();
    t_backpressure();
    t_len_restart();
    t_tx_full();
    t_rx_basic();
    t_rx_full();
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule